// File: doc/BRIEF.md
# PS/2 Mouse Packet Receiver

This block listens to the device-to-host direction of a two-wire PS/2 bus and assembles the three-byte movement packet that a mouse sends in stream mode. The clock and data lines are open-drain and run asynchronously to the system clock. Each line therefore passes through a two-flop synchronizer and then a majority-free glitch filter. A filtered line changes state only after the synchronized input has held a new level for `FILT_LEN` consecutive system cycles.

On every falling edge of the filtered PS/2 clock, the filtered data level is shifted into a 33-bit register. The first bit received settles in the lowest position. After the 33rd bit, the three 11-bit frames are checked together. A clean packet yields a single-cycle `pkt_valid` pulse and updates the three output bytes. A faulty packet yields a single-cycle `pkt_error` pulse instead, and the previous bytes are kept.

A packet that stalls mid-way loses its partial bits after `TIMEOUT_CYC` system cycles without a falling edge. While a companion transmitter owns the bus (`tx_busy`), reception is suspended and the bit count is cleared.

Top module: `ps2_packet_rx`

## Requirements
- R1: After reset, `pkt_valid` and `pkt_error` are 0 and all three output bytes are 0x00.
- R2: The bus bit that arrives at position n (n = 0..32) lands in packet bit n. Frame k occupies bits 11k..11k+10, laid out as follows: the start bit at 11k, data bits with the LSB at 11k+1 through the MSB at 11k+8, parity at 11k+9, and stop at 11k+10. On a clean packet, `pkt_byte0`, `pkt_byte1` and `pkt_byte2` take the data of frames 0, 1 and 2, and `pkt_valid` pulses.
- R3: `pkt_valid` or `pkt_error` is high in the cycle after the `FILT_LEN`+4th rising system edge, counted from the first edge that samples the 33rd PS/2 clock low level.
- R4: A start bit of 1 in any frame gives a `pkt_error` pulse, no `pkt_valid`, and unchanged output bytes.
- R5: A stop bit of 0 in any frame gives a `pkt_error` pulse, no `pkt_valid`, and unchanged output bytes.
- R6: The nine data and parity bits of a frame must contain an odd number of ones. An even count gives a `pkt_error` pulse and no `pkt_valid`.
- R7: A low pulse on the PS/2 clock lasting fewer than `FILT_LEN` system cycles is not counted as a bit.
- R8: When a packet is partially received and `TIMEOUT_CYC` cycles pass without a PS/2 clock falling edge, the partial bits are discarded. The next complete packet is then received correctly.
- R9: While `tx_busy` is high, falling edges are ignored, no pulse is produced, and the bit count returns to 0.
- R10: `pkt_valid` and `pkt_error` are each one cycle wide and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_in | input | 1 | PS/2 clock line level (asynchronous) |
| ps2_dat_in | input | 1 | PS/2 data line level (asynchronous) |
| tx_busy | input | 1 | Companion transmitter holds the bus |
| pkt_byte0 | output | 8 | Data of the first frame received |
| pkt_byte1 | output | 8 | Data of the second frame |
| pkt_byte2 | output | 8 | Data of the third frame |
| pkt_valid | output | 1 | One-cycle pulse for a clean packet |
| pkt_error | output | 1 | One-cycle pulse for a rejected packet |

## Verification
Each result falls due `FILT_LEN`+4 system cycles after the PS/2 clock falls for the 33rd time, and every bench input changes on a falling system edge. A behavioural model in the bench replays the input history through a queue, so it knows the exact cycle in which each pulse and byte update should appear. The outputs are compared against this model on every falling edge. A directed check also counts the cycles between the last clock drop and the `pkt_valid` pulse.

// File: rtl/ps2_packet_rx.sv
module ps2_packet_rx #(
  parameter int FILT_LEN    = 4,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_in,
  input  logic       ps2_dat_in,
  input  logic       tx_busy,
  output logic [7:0] pkt_byte0,
  output logic [7:0] pkt_byte1,
  output logic [7:0] pkt_byte2,
  output logic       pkt_valid,
  output logic       pkt_error
);
  localparam int NBITS = 33;
  localparam int CW    = $clog2(NBITS);
  localparam int TW    = $clog2(TIMEOUT_CYC + 1);

  logic [1:0]          clk_sync, dat_sync;
  logic [FILT_LEN-1:0] clk_win, dat_win;
  logic                clk_f, clk_f_q, dat_f;
  logic [NBITS-1:0]    sreg, sreg_nxt;
  logic [CW-1:0]       bit_cnt;
  logic [TW-1:0]       idle;
  logic                fall, pkt_ok;

  function automatic logic frame_ok(input logic [10:0] fr);
    return !fr[0] && fr[10] && (^fr[9:1]);
  endfunction

  // FILT_LEN must be at least 2
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sync <= '1;
      dat_sync <= '1;
      clk_win  <= '1;
      dat_win  <= '1;
      clk_f    <= 1'b1;
      clk_f_q  <= 1'b1;
      dat_f    <= 1'b1;
    end else begin
      clk_sync <= {clk_sync[0], ps2_clk_in};
      dat_sync <= {dat_sync[0], ps2_dat_in};
      clk_win  <= {clk_win[FILT_LEN-2:0], clk_sync[1]};
      dat_win  <= {dat_win[FILT_LEN-2:0], dat_sync[1]};
      if (&clk_win) clk_f <= 1'b1;
      else if (~|clk_win) clk_f <= 1'b0;
      if (&dat_win) dat_f <= 1'b1;
      else if (~|dat_win) dat_f <= 1'b0;
      clk_f_q <= clk_f;
    end
  end

  assign fall     = clk_f_q & ~clk_f;
  assign sreg_nxt = {dat_f, sreg[NBITS-1:1]};
  assign pkt_ok   = frame_ok(sreg_nxt[10:0]) && frame_ok(sreg_nxt[21:11]) &&
                    frame_ok(sreg_nxt[32:22]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg      <= '0;
      bit_cnt   <= '0;
      idle      <= '0;
      pkt_byte0 <= '0;
      pkt_byte1 <= '0;
      pkt_byte2 <= '0;
      pkt_valid <= 1'b0;
      pkt_error <= 1'b0;
    end else begin
      pkt_valid <= 1'b0;
      pkt_error <= 1'b0;
      if (tx_busy) begin
        bit_cnt <= '0;
        idle    <= '0;
      end else if (fall) begin
        sreg <= sreg_nxt;
        idle <= '0;
        if (bit_cnt == CW'(NBITS - 1)) begin
          bit_cnt <= '0;
          if (pkt_ok) begin
            pkt_valid <= 1'b1;
            pkt_byte0 <= sreg_nxt[8:1];
            pkt_byte1 <= sreg_nxt[19:12];
            pkt_byte2 <= sreg_nxt[30:23];
          end else begin
            pkt_error <= 1'b1;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (bit_cnt != '0) begin
        if (idle == TW'(TIMEOUT_CYC - 1)) begin
          bit_cnt <= '0;
          idle    <= '0;
        end else begin
          idle <= idle + 1'b1;
        end
      end else begin
        idle <= '0;
      end
    end
  end
endmodule

// File: rtl/ps2_packet_rx_chk.sv
module ps2_packet_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_busy,
  input logic       pkt_valid,
  input logic       pkt_error,
  input logic [7:0] b0,
  input logic [7:0] b1,
  input logic [7:0] b2
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) pkt_valid |=> !pkt_valid); // R10
  AST_ERROR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) pkt_error |=> !pkt_error); // R10
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n) !(pkt_valid && pkt_error)); // R10
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n) tx_busy |=> !pkt_valid && !pkt_error); // R9
  AST_BYTES_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n) !$stable({b2, b1, b0}) |-> pkt_valid); // R2
  AST_ERROR_KEEPS_BYTES: assert property (@(posedge clk) disable iff (!rst_n) pkt_error |-> $stable({b2, b1, b0})); // R4
endmodule

bind ps2_packet_rx ps2_packet_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .pkt_valid(pkt_valid),
  .pkt_error(pkt_error), .b0(pkt_byte0), .b1(pkt_byte1), .b2(pkt_byte2)
);

// File: tb/sim_ps2_packet_rx.sv
module sim_ps2_packet_rx;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 4;
  localparam int TMO  = 2000;

  logic clk = 1'b0, rst_n = 1'b0, pclk = 1'b1, pdat = 1'b1, busy = 1'b0;
  logic [7:0] b0, b1, b2;
  logic valid, err;
  int checks = 0, errors = 0, n_valid = 0, n_err = 0, lat = -1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_packet_rx #(.FILT_LEN(FILT), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .ps2_clk_in(pclk), .ps2_dat_in(pdat), .tx_busy(busy),
    .pkt_byte0(b0), .pkt_byte1(b1), .pkt_byte2(b2), .pkt_valid(valid), .pkt_error(err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit qc[$], qd[$];
  bit mfc, mfq, mfd, mbits[33];
  int mcnt, midle;
  bit e_valid, e_err;
  logic [7:0] e0, e1, e2;

  always @(posedge clk) begin
    if (!rst_n) begin
      qc = {}; qd = {};
      for (int i = 0; i < FILT + 2; i++) begin qc.push_back(1'b1); qd.push_back(1'b1); end
      mfc = 1; mfq = 1; mfd = 1; mcnt = 0; midle = 0;
      e_valid = 0; e_err = 0; e0 = 0; e1 = 0; e2 = 0;
    end else begin
      bit fall, dnow, allc1, allc0, alld1, alld0;
      fall = mfq && !mfc;
      dnow = mfd;
      qc.push_back(pclk); qd.push_back(pdat);
      allc1 = 1; allc0 = 1; alld1 = 1; alld0 = 1;
      for (int j = 0; j < FILT; j++) begin
        if (qc[j]) allc0 = 0; else allc1 = 0;
        if (qd[j]) alld0 = 0; else alld1 = 0;
      end
      void'(qc.pop_front()); void'(qd.pop_front());
      mfq = mfc;
      if (allc1) mfc = 1; else if (allc0) mfc = 0;
      if (alld1) mfd = 1; else if (alld0) mfd = 0;
      e_valid = 0; e_err = 0;
      if (busy) begin
        mcnt = 0; midle = 0;
      end else if (fall) begin
        midle = 0;
        mbits[mcnt] = dnow;
        if (mcnt == 32) begin
          bit good;
          logic [7:0] d[3];
          good = 1;
          for (int f = 0; f < 3; f++) begin
            int ones;
            ones = 0;
            for (int k = 1; k <= 9; k++) ones += mbits[11*f+k];
            for (int k = 0; k < 8; k++) d[f][k] = mbits[11*f+1+k];
            if (mbits[11*f] != 0 || mbits[11*f+10] != 1 || ones % 2 == 0) good = 0;
          end
          if (good) begin e_valid = 1; e0 = d[0]; e1 = d[1]; e2 = d[2]; end
          else e_err = 1;
          mcnt = 0;
        end else mcnt++;
      end else if (mcnt != 0) begin
        if (midle == TMO - 1) begin mcnt = 0; midle = 0; end
        else midle++;
      end else midle = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid) n_valid++;
      if (err) n_err++;
      chk(valid == e_valid, "R2/R3 pkt_valid", valid, e_valid);
      chk(err == e_err, "R4/R5/R6 pkt_error", err, e_err);
      chk({b2, b1, b0} == {e2, e1, e0}, "R2 bytes", {b2, b1, b0}, {e2, e1, e0});
      chk(!(valid && err), "R10 exclusive", {valid, err}, 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input bit meas);
    @(negedge clk) pdat = b;
    cyc(9);
    @(negedge clk) pclk = 1'b0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (meas && lat < 0 && (valid || err)) lat = i;
    end
    pclk = 1'b1;
    cyc(10);
  endtask

  // kind: 0 clean, 1 start bit high, 2 stop bit low, 3 parity flipped
  task automatic send_pkt(input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                          input int kind, input int frame, input int nbits);
    logic [32:0] v;
    logic [7:0] d[3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    for (int f = 0; f < 3; f++) begin
      v[11*f] = 1'b0;
      for (int k = 0; k < 8; k++) v[11*f+1+k] = d[f][k];
      v[11*f+9] = ~^d[f];
      v[11*f+10] = 1'b1;
      if (f == frame && kind == 1) v[11*f] = 1'b1;
      if (f == frame && kind == 2) v[11*f+10] = 1'b0;
      if (f == frame && kind == 3) v[11*f+9] = ~v[11*f+9];
    end
    lat = -1;
    for (int i = 0; i < nbits; i++) send_bit(v[i], i == 32);
    pdat = 1'b1;
    cyc(20);
  endtask

  task automatic finish_run;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int nv, ne;
    cyc(5);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(valid == 0 && err == 0 && {b2, b1, b0} == 0, "R1 reset state", {valid, err, b2, b1, b0}, 0);

    send_pkt(8'hA5, 8'h3C, 8'h01, 0, 0, 33);
    chk(n_valid == 1, "R2 clean packet", n_valid, 1);
    chk({b2, b1, b0} == 24'h013CA5, "R2 byte order", {b2, b1, b0}, 24'h013CA5);
    chk(lat == FILT + 4, "R3 latency", lat, FILT + 4);

    send_pkt(8'h00, 8'hFF, 8'h80, 0, 0, 33);
    chk({b2, b1, b0} == 24'h80FF00, "R2 second pattern", {b2, b1, b0}, 24'h80FF00);

    nv = n_valid; ne = n_err;
    send_pkt(8'h11, 8'h22, 8'h33, 1, 1, 33);
    chk(n_err == ne + 1 && n_valid == nv, "R4 start error", n_err - ne, 1);
    chk({b2, b1, b0} == 24'h80FF00, "R4 bytes held", {b2, b1, b0}, 24'h80FF00);
    chk(lat == FILT + 4, "R3 error latency", lat, FILT + 4);

    send_pkt(8'h11, 8'h22, 8'h33, 2, 2, 33);
    chk(n_err == ne + 2 && n_valid == nv, "R5 stop error", n_err - ne, 2);
    chk({b2, b1, b0} == 24'h80FF00, "R5 bytes held", {b2, b1, b0}, 24'h80FF00);

    send_pkt(8'h11, 8'h22, 8'h33, 3, 0, 33);
    chk(n_err == ne + 3 && n_valid == nv, "R6 parity error", n_err - ne, 3);

    @(negedge clk) pclk = 1'b0;
    cyc(FILT - 1);
    pclk = 1'b1;
    cyc(30);
    send_pkt(8'h5A, 8'hC3, 8'h7E, 0, 0, 33);
    chk(n_valid == nv + 1 && {b2, b1, b0} == 24'h7EC35A, "R7 glitch ignored", {b2, b1, b0}, 24'h7EC35A);

    send_pkt(8'hFF, 8'hFF, 8'hFF, 0, 0, 10);
    cyc(TMO + 100);
    send_pkt(8'h12, 8'h34, 8'h56, 0, 0, 33);
    chk(n_valid == nv + 2 && {b2, b1, b0} == 24'h563412, "R8 timeout realign", {b2, b1, b0}, 24'h563412);

    nv = n_valid; ne = n_err;
    send_pkt(8'hFF, 8'hFF, 8'hFF, 0, 0, 5);
    @(negedge clk) busy = 1'b1;
    send_pkt(8'h99, 8'h88, 8'h77, 0, 0, 33);
    chk(n_valid == nv && n_err == ne, "R9 busy silent", n_valid + n_err, nv + ne);
    @(negedge clk) busy = 1'b0;
    cyc(10);
    send_pkt(8'hDE, 8'hAD, 8'hBE, 0, 0, 33);
    chk(n_valid == nv + 1 && {b2, b1, b0} == 24'hBEADDE, "R9 count cleared", {b2, b1, b0}, 24'hBEADDE);
    chk(n_err == ne, "R10 no stray error", n_err, ne);

    cyc(10);
    finish_run();
  end
endmodule